// File: doc/BRIEF.md
# Four-Function ALU with Condition Flags

This block is a stateless arithmetic-logic unit for a word-wide datapath. Two operands, X and Y, enter together with a 2-bit function code. The code picks one of four results: the sum, the difference Y minus X, the bitwise AND, or the bitwise XOR. Alongside the result, the block reports three condition flags: carry, zero and signed overflow.

No clock is involved. Every output is a pure function of the present inputs, so a surrounding pipeline can place the block between any two register stages. Internally, a small decoder turns the function code into a struct of strobes. A datapath uses those strobes to steer one shared ripple adder and a logic unit. The subtract path inverts X and feeds in a carry of 1.

Top module: `quad_alu`

## Requirements
- R1: With function code 0, the result equals (X + Y) modulo 2^WIDTH.
- R2: With function code 1, the result equals (Y − X) modulo 2^WIDTH, formed as Y + ~X + 1.
- R3: With function code 2, the result equals X AND Y, bit by bit.
- R4: With function code 3, the result equals X XOR Y, bit by bit.
- R5: With code 0, the carry flag is the carry out of the unsigned WIDTH-bit sum. With code 1, the carry flag is 1 exactly when Y ≥ X, taken as unsigned values (no borrow).
- R6: With code 0, the overflow flag is 1 exactly when X and Y have the same sign bit and the result's sign bit differs from it. With code 1, the overflow flag is 1 exactly when X and Y have different sign bits and the result's sign bit differs from Y's.
- R7: For every function code, the zero flag is 1 exactly when all result bits are 0.
- R8: With codes 2 and 3, the carry and overflow flags are both 0.
- R9: All outputs follow an input change without any clock edge.
- R10: WIDTH is a parameter with a default of 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fnCode | input | 2 | Function select: 0 add, 1 subtract (Y−X), 2 AND, 3 XOR |
| opX | input | WIDTH | Operand X (the subtrahend when subtracting) |
| opY | input | WIDTH | Operand Y (the minuend when subtracting) |
| result | output | WIDTH | Selected function result |
| carryFlag | output | 1 | Unsigned carry out, or no-borrow when subtracting |
| zeroFlag | output | 1 | Result is all zero |
| ovfFlag | output | 1 | Signed overflow of the add or subtract |

## Verification
Carry and signed overflow can be raised by the same operation. Zero can join them as well. The bench provokes this with operand pairs built from the extreme values 0, 1, all ones, the most negative and the most positive number. For example, adding the most negative number to itself wraps to zero with both carry and overflow set. Each flag in such a cycle is judged on its own against a behavioural model that uses wide integer arithmetic, and so does every random vector on every function code.

// File: rtl/quad_alu_pkg.sv
package quad_alu_pkg;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_AND = 2'd2,
    FN_XOR = 2'd3
  } aluFn_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic negX;     // invert X before the adder
    logic carryIn;  // adder carry-in
    logic arith;    // result comes from the adder
    logic pickXor;  // logic unit gives XOR instead of AND
  } aluStrobe_s;

endpackage

// File: rtl/quad_alu_ctrl.sv
module quad_alu_ctrl
  import quad_alu_pkg::*;
(
  input  logic [1:0] fnCode,
  output aluStrobe_s strobe
);

  always_comb begin
    strobe = '0;
    unique case (aluFn_e'(fnCode))
      FN_ADD: strobe.arith = 1'b1;
      FN_SUB: begin
        strobe.arith   = 1'b1;
        strobe.negX    = 1'b1;
        strobe.carryIn = 1'b1;
      end
      FN_AND: strobe.pickXor = 1'b0;
      FN_XOR: strobe.pickXor = 1'b1;
      default: strobe = '0;
    endcase
  end

endmodule

// File: rtl/quad_alu_datapath.sv
module quad_alu_datapath
  import quad_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  aluStrobe_s       strobe,
  input  logic [WIDTH-1:0] opX,
  input  logic [WIDTH-1:0] opY,
  output logic [WIDTH-1:0] result,
  output logic             carryFlag,
  output logic             ovfFlag,
  output logic             zeroFlag
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] addB;
  logic [WIDTH-1:0] sumBits;
  logic [WIDTH:0]   chain;
  logic [WIDTH-1:0] logicRes;

  assign addB     = strobe.negX ? ~opX : opX;
  assign chain[0] = strobe.carryIn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_rip
    assign sumBits[i]   = opY[i] ^ addB[i] ^ chain[i];
    assign chain[i + 1] = (opY[i] & addB[i]) | (chain[i] & (opY[i] ^ addB[i]));
  end

  assign logicRes  = strobe.pickXor ? (opX ^ opY) : (opX & opY);
  assign result    = strobe.arith ? sumBits : logicRes;
  assign carryFlag = strobe.arith & chain[WIDTH];
  assign ovfFlag   = strobe.arith & (opY[MSB] == addB[MSB]) & (sumBits[MSB] != opY[MSB]);
  assign zeroFlag  = ~|result;

  // R1 / R2: the bit chain must agree with a word-level sum
  always_comb begin
    if (!$isunknown({opY, addB, strobe})) begin
      a_r1_ripple_matches_sum: assert ({chain[WIDTH], sumBits} ==
        ({1'b0, opY} + {1'b0, addB} + {{WIDTH{1'b0}}, strobe.carryIn}))
        else $error("ripple chain disagrees with word sum");
    end
  end

endmodule

// File: rtl/quad_alu.sv
module quad_alu
  import quad_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [1:0]       fnCode,
  input  logic [WIDTH-1:0] opX,
  input  logic [WIDTH-1:0] opY,
  output logic [WIDTH-1:0] result,
  output logic             carryFlag,
  output logic             zeroFlag,
  output logic             ovfFlag
);

  localparam int MSB = WIDTH - 1;

  aluStrobe_s strobe;

  quad_alu_ctrl ctrl_i (
    .fnCode (fnCode),
    .strobe (strobe)
  );

  quad_alu_datapath #(.WIDTH(WIDTH)) dp_i (
    .strobe    (strobe),
    .opX       (opX),
    .opY       (opY),
    .result    (result),
    .carryFlag (carryFlag),
    .ovfFlag   (ovfFlag),
    .zeroFlag  (zeroFlag)
  );

  always_comb begin
    if (!$isunknown({fnCode, opX, opY, result, carryFlag, ovfFlag})) begin
      if (fnCode[1]) begin
        a_r8_logic_flags_clear: assert (!carryFlag && !ovfFlag)
          else $error("logic op raised carry or overflow");
      end
      if (fnCode == 2'd1) begin
        a_r5_sub_no_borrow: assert (carryFlag == (opY >= opX))
          else $error("subtract carry is not the no-borrow flag");
      end
      if (fnCode == 2'd0) begin
        a_r6_add_overflow: assert (ovfFlag ==
          ((opX[MSB] == opY[MSB]) && (result[MSB] != opX[MSB])))
          else $error("add overflow flag wrong");
      end
    end
  end

endmodule

// File: tb/quad_alu_tb_top.sv
`timescale 1ns/1ps
module quad_alu_tb_top;

  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [1:0]   fnCode = '0;
  logic [W-1:0] opX = '0;
  logic [W-1:0] opY = '0;
  logic [W-1:0] result;
  logic         carryFlag, zeroFlag, ovfFlag;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  quad_alu #(.WIDTH(W)) dut_i (
    .fnCode(fnCode), .opX(opX), .opY(opY),
    .result(result), .carryFlag(carryFlag),
    .zeroFlag(zeroFlag), .ovfFlag(ovfFlag)
  );

  task automatic cmp(input string req, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s fn=%0d x=%h y=%h actual=%h expected=%h",
               req, fnCode, opX, opY, act, exp);
    end
  endtask

  // Behavioural model with wide integers; drive after an edge, sample 1 ns later (R9)
  task automatic apply(input logic [1:0] f, input logic [W-1:0] x, input logic [W-1:0] y);
    longint ux, uy, sx, sy, wide, smax, smin;
    logic [W-1:0] er;
    logic ec, eo;
    string rq;
    @(posedge clk);
    fnCode = f; opX = x; opY = y;
    ux = longint'(x); uy = longint'(y);
    sx = longint'($signed(x)); sy = longint'($signed(y));
    smax = (longint'(1) <<< (W - 1)) - 1;
    smin = -(longint'(1) <<< (W - 1));
    ec = 0; eo = 0;
    case (f)
      2'd0: begin
        wide = ux + uy; er = W'(wide); ec = wide >= (longint'(1) <<< W);
        wide = sx + sy; eo = (wide > smax) || (wide < smin); rq = "R1";
      end
      2'd1: begin
        er = W'(uy - ux); ec = uy >= ux;
        wide = sy - sx; eo = (wide > smax) || (wide < smin); rq = "R2";
      end
      2'd2: begin er = x & y; rq = "R3"; end
      default: begin er = x ^ y; rq = "R4"; end
    endcase
    #1;
    cmp({rq, "/R9 result"}, longint'(result), longint'(er));
    cmp(f[1] ? "R8 carry" : "R5 carry", longint'(carryFlag), longint'(ec));
    cmp(f[1] ? "R8 overflow" : "R6 overflow", longint'(ovfFlag), longint'(eo));
    cmp("R7 zero", longint'(zeroFlag), longint'(er == '0));
  endtask

  initial begin
    logic [W-1:0] corner [5];
    corner[0] = '0;
    corner[1] = W'(1);
    corner[2] = '1;
    corner[3] = {1'b1, {(W-1){1'b0}}};
    corner[4] = {1'b0, {(W-1){1'b1}}};
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // reset state: all-zero inputs give zero result with only the zero flag up (R7, R10 default width)
    #1;
    cmp("R7 reset zero", longint'(zeroFlag), 1);
    cmp("R10 reset result", longint'(result), 0);
    // flags together: min+min wraps to 0 with carry and overflow (R5, R6, R7)
    apply(2'd0, corner[3], corner[3]);
    for (int f = 0; f < 4; f++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          apply(2'(f), corner[i], corner[j]);
    // equal operands on subtract: zero with carry set (R2, R5)
    apply(2'd1, W'(32'h1234_5678), W'(32'h1234_5678));
    for (int n = 0; n < 300; n++)
      for (int f = 0; f < 4; f++)
        apply(2'(f), W'($urandom), W'($urandom));
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule